// File: doc/BRIEF.md
# Runt-Free Differential Clock Pair Gate

This block sits between a reference clock and a bank of differential clock output pads. From one reference clock and a vector of per-pair enable bits written by configuration registers, it produces for every pair a true drive level, a complement drive level and an output-enable for the pad's tri-state driver. It also produces a feedback clock that always runs, whatever the enables say. The feedback clock is meant to close an external loop back to the clock source.

The enable bits may change at any time relative to the reference clock. Each bit is first brought into the clock domain through a two-flop synchronizer. It is then captured into a per-pair gate on the falling edge of the reference clock. A pair therefore starts or stops only while its true output is low. A pair being switched off always finishes its current high phase. A pair being switched on always starts with a complete low phase on the true side and a complete high phase on the complement side. When a pair's output-enable is low, the pad floats. The true and complement levels are then parked low behind it.

Top module: `clkpair_gate`

## Requirements
- R1: While a pair's output-enable is 1, its complement output is the inverse of its true output, sampled in both the high and the low phase of the reference clock.
- R2: While a pair's output-enable is 0, the pad is high impedance. Its true and complement drive levels are both 0.
- R3: Enable bit p (bit index p of `en_cfg`) controls pair p alone. Changing one bit leaves every other pair's outputs and output-enable unchanged.
- R4: No runt pulses. Within any half period of the reference clock, every output of an enabled pair holds one level for the whole half period. A pair being disabled completes its full high phase before its output-enable falls.
- R5: `fb_out` equals `ref_clk` at all times, independent of `en_cfg` and `rst`.
- R6: Suppose an enable bit changes while `ref_clk` is low, after a falling edge. The output-enable then changes on the falling edge that follows the second rising edge after the change, and at no earlier edge.
- R7: When a pair is switched on, its first driven phase has the true output at 0 and the complement output at 1. Its first high pulse on the true output is a full high phase.
- R8: `rst` is synchronous and active high. Once `rst` has been sampled at a falling edge, every pair's output-enable is 0. After release, each pair whose enable bit is 1 turns on with the R6 latency, counted from the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; also the clock of all internal flops |
| rst | input | 1 | Synchronous active-high reset |
| en_cfg | input | N_PAIRS | Per-pair enable bits from configuration registers (asynchronous to ref_clk); bit p enables pair p |
| out_true | output | N_PAIRS | True drive level of each pair |
| out_comp | output | N_PAIRS | Complement drive level of each pair |
| out_oe | output | N_PAIRS | Pad output-enable of each pair; 0 means high impedance |
| fb_out | output | 1 | Free-running feedback clock, equal to ref_clk |

## Verification
The assertions assume that `ref_clk` runs with a steady period. They also assume that `rst` is held through at least one falling and one rising edge before any check applies. The latency property assumes that the synchronizer output is the only source of gate changes. It therefore relies on `en_cfg` being quasi-static, so that a changed value is held for more than two reference cycles. The stimulus satisfies these assumptions. It changes `en_cfg` and `rst` only one time unit after a falling edge, so no input ever moves near an active edge. It then holds each value for at least three full clock periods before the next change.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    // Gate state of one differential pair
    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_state_t;

    // Drive bundle handed to one pad pair
    typedef struct packed {
        logic tru;
        logic cmp;
        logic oe;
    } pair_drive_t;

    // Form the pad drive from the clock level and the gate state.
    // A closed gate parks both levels low behind a floating pad.
    function automatic pair_drive_t drive_of(input logic clk_lvl, input gate_state_t st);
        pair_drive_t d;
        d.oe  = (st == GATE_ON);
        d.tru = clk_lvl & d.oe;
        d.cmp = ~clk_lvl & d.oe;
        return d;
    endfunction

endpackage

// File: rtl/cg_enable_sync.sv
module cg_enable_sync #(
    parameter int WIDTH  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[LAST];

endmodule

// File: rtl/cg_pair_gate.sv
module cg_pair_gate
    import clkgate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en_sync,
    output pair_drive_t drv
);
    gate_state_t state_q;

    // Capture on the falling edge: the true level is low, so the gate
    // can open or close without cutting a pulse short.
    always_ff @(negedge clk) begin
        if (rst) begin
            state_q <= GATE_OFF;
        end else begin
            state_q <= en_sync ? GATE_ON : GATE_OFF;
        end
    end

    assign drv = drive_of(clk, state_q);

    AST_COMP_INV_HI: assert property (@(posedge clk) disable iff (rst)
        drv.oe |-> (drv.cmp == ~drv.tru)); // R1

    AST_COMP_INV_LO: assert property (@(negedge clk) disable iff (rst)
        drv.oe |-> (drv.cmp == ~drv.tru)); // R1

    AST_PARK_LOW: assert property (@(posedge clk) disable iff (rst)
        !drv.oe |-> (!drv.tru && !drv.cmp)); // R2

    AST_GATE_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (drv.oe == en_sync)); // R6

endmodule

// File: rtl/clkpair_gate.sv
module clkpair_gate
    import clkgate_pkg::*;
#(
    parameter int N_PAIRS     = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic               ref_clk,
    input  logic               rst,
    input  logic [N_PAIRS-1:0] en_cfg,
    output logic [N_PAIRS-1:0] out_true,
    output logic [N_PAIRS-1:0] out_comp,
    output logic [N_PAIRS-1:0] out_oe,
    output logic               fb_out
);
    logic [N_PAIRS-1:0] en_sync;
    pair_drive_t        drv [N_PAIRS];

    cg_enable_sync #(
        .WIDTH  (N_PAIRS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (ref_clk),
        .rst  (rst),
        .din  (en_cfg),
        .dout (en_sync)
    );

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        cg_pair_gate u_gate (
            .clk     (ref_clk),
            .rst     (rst),
            .en_sync (en_sync[p]),
            .drv     (drv[p])
        );
        assign out_true[p] = drv[p].tru;
        assign out_comp[p] = drv[p].cmp;
        assign out_oe[p]   = drv[p].oe;
    end

    // Feedback path is never gated
    assign fb_out = ref_clk;

endmodule

// File: tb/clkpair_gate_bench.sv
module clkpair_gate_bench;
    localparam int N = 10;
    localparam int NV = 6;
    localparam logic [N-1:0] VEC [NV] = '{10'h3FF, 10'h000, 10'h155, 10'h2AA, 10'h001, 10'h200};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] en  = '0;
    logic [N-1:0] o_t, o_c, o_e;
    logic         fb;
    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    clkpair_gate u_clkpair_gate (
        .ref_clk (clk), .rst (rst), .en_cfg (en),
        .out_true (o_t), .out_comp (o_c), .out_oe (o_e), .fb_out (fb)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Wait for the next phase, check early in it, then check late (R4)
    task automatic phase(input bit high, input logic [N-1:0] e_oe, input string tag);
        logic [N-1:0] e_t, e_c;
        e_t = high ? e_oe : '0;
        e_c = high ? '0 : e_oe;
        if (high) @(posedge clk); else @(negedge clk);
        #1;
        chk({tag, " oe"},   o_e, e_oe);
        chk({tag, " true"}, o_t, e_t);
        chk({tag, " comp"}, o_c, e_c);
        chk({tag, " R5 fb"}, {{(N-1){1'b0}}, fb}, {{(N-1){1'b0}}, high});
        #2;
        chk({tag, " R4 true late"}, o_t, e_t);
        chk({tag, " R4 comp late"}, o_c, e_c);
    endtask

    task automatic set_en(input logic [N-1:0] v);
        @(negedge clk); #1; en = v;
    endtask

    initial begin
        // R8: reset state
        en = 10'h3FF;
        repeat (3) @(posedge clk);
        phase(0, '0, "R8 reset low");
        phase(1, '0, "R8 reset high");
        @(negedge clk); #1; rst = 1'b0;
        phase(1, '0, "R8 release P1");
        phase(0, '0, "R8 release N1");
        phase(1, '0, "R8 release P2");
        phase(0, 10'h3FF, "R8 R7 release N2");

        // R1 R2 R3: vector table
        for (int i = 0; i < NV; i++) begin
            set_en(VEC[i]);
            repeat (3) @(posedge clk);
            phase(0, VEC[i], "R1 R2 R3 table low");
            phase(1, VEC[i], "R1 R2 R3 table high");
        end

        // R6 R4 R3: disable pair 3, others stay on
        set_en(10'h3FF); repeat (3) @(posedge clk);
        set_en(10'h3F7);
        phase(1, 10'h3FF, "R6 dis P1");
        phase(0, 10'h3FF, "R6 dis N1");
        phase(1, 10'h3FF, "R4 dis full high P2");
        phase(0, 10'h3F7, "R6 R3 dis N2");
        phase(1, 10'h3F7, "R3 dis after");

        // R6 R7: enable pair 9 from all off
        set_en(10'h000); repeat (3) @(posedge clk);
        set_en(10'h200);
        phase(1, 10'h000, "R6 en P1");
        phase(0, 10'h000, "R6 en N1");
        phase(1, 10'h000, "R6 en P2");
        phase(0, 10'h200, "R7 en first low");
        phase(1, 10'h200, "R7 en first high");

        // R8: reset while running; R5 feedback under reset
        set_en(10'h3FF); repeat (3) @(posedge clk);
        @(negedge clk); #1; rst = 1'b1;
        phase(1, 10'h3FF, "R8 assert P1");
        phase(0, '0, "R8 R5 assert N1");
        phase(1, '0, "R8 R5 held");
        @(negedge clk); #1; rst = 1'b0;
        repeat (3) @(posedge clk);
        phase(0, 10'h3FF, "R8 recover");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule